// File: doc/BRIEF.md
# Supply Fail Reset Sequencer

This block watches three digitised supply-level flags from external comparators and turns them into the control signals a battery-backed storage array needs during power transitions. The flags report whether the supply is above the full-operation level (about 3.0 V), above the write-protect trip level (about 2.8 V), and above the battery switchover level (about 2.5 V). From these the block produces a write-protect signal, a select that chooses between the backup battery and the external supply, and an active-low reset. The reset leaves the block as a pull-low enable, so an open-drain pad can drive it.

When the supply leaves tolerance, reset and write protect assert at once. When the supply returns, both stay asserted for a fixed number of millisecond tick pulses (nominally 200). The end of that hold is also reported on a separate recovery-complete output for neighbouring blocks. If the supply drops again before the hold ends, the count starts over. The comparator flags are asynchronous, so they pass through a synchroniser first. They are then forced into a consistent order: a higher level only counts while every lower level is also present.

Top module: `supply_guard_seq`

## Requirements
- R1: After a synchronous reset, rst_pull_en=1, wr_protect=1, src_batt=1 and rec_done=0 until the supply flags say otherwise.
- R2: The flags are ordered before use. The operating level counts only when the write-protect and switchover flags are also 1. The write-protect level counts only when the switchover flag is 1.
- R3: wr_protect=1 in every cycle in which reset is asserted, including the whole hold. It falls in the same cycle that rst_pull_en falls.
- R4: A loss of the ordered operating level asserts rst_pull_en=1 exactly SYNC_STAGES+1 clock edges after the raw flag change is sampled.
- R5: src_batt=1 (battery) while the ordered switchover flag is 0, and src_batt=0 (external supply) while it is 1. It follows the raw flag with a latency of SYNC_STAGES+1 edges.
- R6: rec_done=1 exactly when the hold has completed and the supply is still in tolerance, so it is always the complement of rst_pull_en.
- R7: Once the synchronised supply is in tolerance, reset releases at the clock edge that samples the HOLD_TICKS-th ms_tick pulse seen while holding. The edge that starts the hold does not count its tick, and no earlier tick releases it.
- R8: A loss of tolerance during the hold returns the tick count to zero. The next recovery again needs the full HOLD_TICKS ticks.
- R9: If a loss of tolerance and the final hold tick reach the sequencer at the same edge, the loss wins and reset stays asserted.
- R10: The reset output is a single pull-low enable: 1 means the pin is pulled low, and 0 means it floats. The block never drives it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond, in the clk domain |
| lvl_op_raw | input | 1 | Comparator: supply above operating level (asynchronous) |
| lvl_wp_raw | input | 1 | Comparator: supply above write-protect trip (asynchronous) |
| lvl_sw_raw | input | 1 | Comparator: supply above switchover level (asynchronous) |
| rst_pull_en | output | 1 | Open-drain reset: 1 pulls the active-low pin low |
| wr_protect | output | 1 | 1 blocks writes to the storage array |
| src_batt | output | 1 | 1 selects the backup battery, 0 the external supply |
| rec_done | output | 1 | Recovery hold has elapsed and the supply is in tolerance |

## Verification
The hold counter can see its final tick in the same cycle that the synchronised operating flag falls, so expiry and supply loss can collide. The bench brings the count to HOLD_TICKS-1. It then lowers the raw flag exactly SYNC_STAGES cycles before it pulses the tick, so both reach the sequencer at one edge. The per-cycle reference model and a directed check expect reset to remain asserted. A second collision is also provoked, a one-cycle dip in the middle of the hold, and the bench then confirms that a full HOLD_TICKS ticks are needed again.

// File: rtl/sgs_pkg.sv
package sgs_pkg;

  // Sequencer phases: supply out of tolerance, recovery hold, normal running
  typedef enum logic [1:0] {
    PH_DOWN = 2'd0,
    PH_HOLD = 2'd1,
    PH_UP   = 2'd2
  } phase_e;

  // Comparator flag bundle; bit order used by the synchroniser
  typedef struct packed {
    logic op;  // above operating level
    logic wp;  // above write-protect trip
    logic sw;  // above switchover level
  } lvl_t;

  localparam int LVL_W = $bits(lvl_t);

endpackage

// File: rtl/sgs_flag_sync.sv
module sgs_flag_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  // Shift chain; every stage clears to "below level" on reset
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_async;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_sync = chain_q[LAST];

endmodule

// File: rtl/sgs_level_order.sv
module sgs_level_order
  import sgs_pkg::*;
(
  input  lvl_t lvl_s,
  output logic sw_ok,
  output logic wp_ok,
  output logic op_ok
);

  // A higher threshold only counts while all lower ones are met
  always_comb begin
    sw_ok = lvl_s.sw;
    wp_ok = lvl_s.wp & sw_ok;
    op_ok = lvl_s.op & wp_ok;
  end

endmodule

// File: rtl/sgs_hold_timer.sv
module sgs_hold_timer
  import sgs_pkg::*;
#(
  parameter int HOLD_TICKS = 200,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             in_tol,
  output phase_e           ph_nx,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_TICKS - 1);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    ph_nx  = ph_q;
    cnt_nx = cnt_q;
    unique case (ph_q)
      PH_DOWN: begin
        cnt_nx = '0;
        if (in_tol) ph_nx = PH_HOLD;
      end
      PH_HOLD: begin
        if (!in_tol) begin
          // supply loss beats a coinciding final tick
          ph_nx  = PH_DOWN;
          cnt_nx = '0;
        end else if (tick) begin
          if (cnt_q == CNT_LAST) begin
            ph_nx  = PH_UP;
            cnt_nx = '0;
          end else begin
            cnt_nx = cnt_q + 1'b1;
          end
        end
      end
      PH_UP: begin
        cnt_nx = '0;
        if (!in_tol) ph_nx = PH_DOWN;
      end
      default: begin
        ph_nx  = PH_DOWN;
        cnt_nx = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_DOWN;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_nx;
      cnt_q <= cnt_nx;
    end
  end

endmodule

// File: rtl/sgs_out_regs.sv
module sgs_out_regs
  import sgs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e ph_nx,
  input  logic   sw_ok,
  output logic   rst_pull_en,
  output logic   wr_protect,
  output logic   src_batt,
  output logic   rec_done
);

  // Outputs are flops loaded from the next phase, so they track the
  // sequencer state without a decode stage behind the register
  always_ff @(posedge clk) begin
    if (rst) begin
      rst_pull_en <= 1'b1;
      wr_protect  <= 1'b1;
      src_batt    <= 1'b1;
      rec_done    <= 1'b0;
    end else begin
      rst_pull_en <= (ph_nx != PH_UP);
      wr_protect  <= (ph_nx != PH_UP);
      src_batt    <= ~sw_ok;
      rec_done    <= (ph_nx == PH_UP);
    end
  end

endmodule

// File: rtl/supply_guard_seq.sv
module supply_guard_seq
  import sgs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_TICKS  = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick,
  input  logic lvl_op_raw,
  input  logic lvl_wp_raw,
  input  logic lvl_sw_raw,
  output logic rst_pull_en,
  output logic wr_protect,
  output logic src_batt,
  output logic rec_done
);

  localparam int CNT_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;

  lvl_t             lvl_raw;
  lvl_t             lvl_s;
  logic             lvl_sw;
  logic             lvl_wp;
  logic             lvl_op;
  phase_e           ph_nx;
  logic [CNT_W-1:0] hold_cnt;

  assign lvl_raw = '{op: lvl_op_raw, wp: lvl_wp_raw, sw: lvl_sw_raw};

  sgs_flag_sync #(
    .WIDTH  (LVL_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (lvl_raw),
    .q_sync  (lvl_s)
  );

  sgs_level_order u_order (
    .lvl_s (lvl_s),
    .sw_ok (lvl_sw),
    .wp_ok (lvl_wp),
    .op_ok (lvl_op)
  );

  sgs_hold_timer #(
    .HOLD_TICKS (HOLD_TICKS),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .tick   (ms_tick),
    .in_tol (lvl_op),
    .ph_nx  (ph_nx),
    .cnt_q  (hold_cnt)
  );

  sgs_out_regs u_out (
    .clk         (clk),
    .rst         (rst),
    .ph_nx       (ph_nx),
    .sw_ok       (lvl_sw),
    .rst_pull_en (rst_pull_en),
    .wr_protect  (wr_protect),
    .src_batt    (src_batt),
    .rec_done    (rec_done)
  );

endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk #(
  parameter int HOLD_TICKS = 200,
  parameter int CNT_W      = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ms_tick,
  input logic             op_ok,
  input logic             sw_ok,
  input logic [CNT_W-1:0] hold_cnt,
  input logic             rst_pull_en,
  input logic             wr_protect,
  input logic             src_batt,
  input logic             rec_done
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_TICKS - 1);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rst_pull_en && wr_protect && src_batt && !rec_done));

  p_drop_protects_r3: assert property (@(posedge clk) disable iff (rst)
    !op_ok |=> wr_protect);

  p_unprotect_in_tol_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_protect |-> $past(op_ok));

  p_drop_resets_r4: assert property (@(posedge clk) disable iff (rst)
    !op_ok |=> rst_pull_en);

  p_batt_on_low_r5: assert property (@(posedge clk) disable iff (rst)
    !sw_ok |=> src_batt);

  p_ext_on_high_r5: assert property (@(posedge clk) disable iff (rst)
    sw_ok |=> !src_batt);

  p_rec_matches_reset_r6: assert property (@(posedge clk) disable iff (rst)
    rec_done != rst_pull_en);

  p_release_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_pull_en) |-> $past(ms_tick));

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    hold_cnt <= CNT_LAST);

  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    !op_ok |=> (hold_cnt == '0));

endmodule

bind supply_guard_seq supply_guard_chk #(
  .HOLD_TICKS (HOLD_TICKS),
  .CNT_W      (CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ms_tick     (ms_tick),
  .op_ok       (lvl_op),
  .sw_ok       (lvl_sw),
  .hold_cnt    (hold_cnt),
  .rst_pull_en (rst_pull_en),
  .wr_protect  (wr_protect),
  .src_batt    (src_batt),
  .rec_done    (rec_done)
);

// File: tb/supply_guard_seq_tb_top.sv
module supply_guard_seq_tb_top;

  localparam int SYNC = 2;
  localparam int HOLD = 5;
  localparam int LAT  = SYNC + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic op_i = 1'b0, wp_i = 1'b0, sw_i = 1'b0;
  logic rst_pull_en, wr_protect, src_batt, rec_done;

  int  n_vec  = 0;
  int  n_fail = 0;
  bit  cmp_on = 1'b0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  supply_guard_seq #(
    .SYNC_STAGES (SYNC),
    .HOLD_TICKS  (HOLD)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .ms_tick     (tick),
    .lvl_op_raw  (op_i),
    .lvl_wp_raw  (wp_i),
    .lvl_sw_raw  (sw_i),
    .rst_pull_en (rst_pull_en),
    .wr_protect  (wr_protect),
    .src_batt    (src_batt),
    .rec_done    (rec_done)
  );

  // Behavioural reference: flag history queue plus a phase number and a tick tally
  logic [2:0] hist[$];
  int m_ph  = 0;   // 0 down, 1 holding, 2 running
  int m_cnt = 0;
  bit m_batt = 1'b1;

  always @(posedge clk) begin
    logic [2:0] d;
    bit op_e, sw_e;
    if (rst) begin
      hist = {};
      repeat (SYNC) hist.push_back(3'b000);
      m_ph = 0; m_cnt = 0; m_batt = 1'b1;
    end else begin
      d = hist.pop_front();
      hist.push_back({op_i, wp_i, sw_i});
      sw_e = d[0];
      op_e = d[2] && d[1] && d[0];           // R2 ordering
      m_batt = !sw_e;
      if (!op_e) begin
        m_ph = 0; m_cnt = 0;                  // R4, R8, R9
      end else if (m_ph == 0) begin
        m_ph = 1; m_cnt = 0;
      end else if (m_ph == 1 && tick) begin
        m_cnt++;
        if (m_cnt == HOLD) begin m_ph = 2; m_cnt = 0; end  // R7
      end
    end
  end

  task automatic chk(input bit got, input bit exp, input string tag, input string what);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk(rst_pull_en, m_ph != 2, "R4", "rst_pull_en vs model");
      chk(wr_protect,  m_ph != 2, "R3", "wr_protect vs model");
      chk(src_batt,    m_batt,    "R5", "src_batt vs model");
      chk(rec_done,    m_ph == 2, "R6", "rec_done vs model");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) pulse_tick();
  endtask

  task automatic set_lvl(input bit o, input bit w, input bit s);
    @(negedge clk);
    op_i = o; wp_i = w; sw_i = s;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(4);
    // R1 and R10: reset values, reset expressed as pull-low enable
    chk(rst_pull_en, 1'b1, "R1", "reset rst_pull_en");
    chk(wr_protect,  1'b1, "R1", "reset wr_protect");
    chk(src_batt,    1'b1, "R1", "reset src_batt");
    chk(rec_done,    1'b0, "R1", "reset rec_done");
    @(negedge clk) rst = 1'b0;
    cmp_on = 1'b1;
    cyc(3);
    chk(rst_pull_en, 1'b1, "R10", "pull-low held with supply absent");

    // Ordered power-up
    set_lvl(0, 0, 1);
    cyc(LAT);
    chk(src_batt, 1'b0, "R5", "external supply after switchover");
    set_lvl(0, 1, 1);
    set_lvl(1, 1, 1);
    cyc(LAT + 1);
    ticks(HOLD - 1);
    chk(rst_pull_en, 1'b1, "R7", "held one tick short");
    chk(wr_protect,  1'b1, "R3", "protected during hold");
    pulse_tick();
    chk(rst_pull_en, 1'b0, "R7", "released on last tick");
    chk(wr_protect,  1'b0, "R3", "unprotected with release");
    chk(rec_done,    1'b1, "R6", "recovery done");

    // Loss of operating level only
    set_lvl(0, 1, 1);
    cyc(LAT - 1);
    chk(rst_pull_en, 1'b0, "R4", "not yet asserted before latency");
    cyc(1);
    chk(rst_pull_en, 1'b1, "R4", "asserted after latency");
    chk(src_batt,    1'b0, "R5", "still external above switchover");

    // Restart on dip during hold
    set_lvl(1, 1, 1);
    cyc(LAT + 1);
    ticks(HOLD - 1);
    set_lvl(0, 1, 1);
    set_lvl(1, 1, 1);
    cyc(LAT + 1);
    ticks(HOLD - 1);
    chk(rst_pull_en, 1'b1, "R8", "count restarted after dip");
    pulse_tick();
    chk(rst_pull_en, 1'b0, "R8", "released after full recount");

    // Ordering: op without wp, then op and wp without sw
    set_lvl(1, 0, 1);
    cyc(LAT);
    chk(rst_pull_en, 1'b1, "R2", "op ignored without wp");
    set_lvl(1, 1, 0);
    cyc(LAT);
    chk(src_batt,    1'b1, "R2", "battery when sw low");
    chk(wr_protect,  1'b1, "R2", "protected when sw low");

    // Loss and final tick meet at one edge
    set_lvl(1, 1, 1);
    cyc(LAT + 1);
    ticks(HOLD - 1);
    @(negedge clk) op_i = 1'b0;
    @(negedge clk);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    chk(rst_pull_en, 1'b1, "R9", "loss wins over final tick");
    chk(rec_done,    1'b0, "R9", "no recovery on collision");

    // Full power-down
    set_lvl(0, 0, 0);
    cyc(LAT);
    chk(src_batt, 1'b1, "R5", "battery after full loss");

    // Random stretch compared against the model each cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tick = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 29) == 0) begin
        int lvl;
        lvl = $urandom_range(0, 3);
        op_i = (lvl >= 3); wp_i = (lvl >= 2); sw_i = (lvl >= 1);
        if ($urandom_range(0, 4) == 0) begin
          op_i = $urandom_range(0, 1); wp_i = $urandom_range(0, 1); sw_i = $urandom_range(0, 1);
        end
      end
    end
    tick = 1'b0;
    cyc(5);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule